// File: doc/BRIEF.md
# HDMI Audio Sample Formatter

This block sits between a ring-buffer reader and an HDMI/DP audio packetizer. It accepts 32-bit words from the reader over a valid/ready handshake and hands out one 24-bit audio sample per channel slot. Each sample comes with its channel index, a marker on the first slot of each sample instant, and a flag on inserted padding slots. A small mode word and a channel-count field set how each container is unpacked and how the frame is built. The downstream stage adds the four status bits that make up the 28-bit transport word.

Channels of one sample instant leave back to back, in the order they arrive. When a frame has an odd channel count, one zero-valued padding slot can close it. When the reader runs dry, the block either keeps the frame cadence going with zero samples or stops producing and raises a null-packet flag. Mode changes take effect only between frames, so no frame ever mixes two layouts.

Top module: `aud_slot_formatter`

## Requirements
- R1: After reset `out_valid`, `out_null` and `out_dp` are 0, the held mode is all-zero with one channel, and `in_ready` is 1.
- R2: With `mode_bits[1]` and `mode_bits[2]` both 0, each accepted word yields one sample equal to `in_data[23:0]`.
- R3: With `mode_bits[2]`=1 and `mode_bits[1]`=0, each accepted word yields one sample equal to `in_data[31:8]`.
- R4: With `mode_bits[1]`=1, each word holds two 16-bit samples. The low half is emitted first and the high half second, each as `{half,8'h00}`. No new word is accepted while the high half is still pending.
- R5: A frame carries N = `chan_m1`+1 real slots with `out_chan` running 0..N-1. `out_first` is 1 exactly when `out_chan` is 0.
- R6: With `mode_bits[3]`=0 and N odd, slot index N follows the last real slot with sample 0 and `out_pad`=1, and no input is consumed for it. With `mode_bits[3]`=1 no padding slot appears.
- R7: With no buffered half and no input word, `mode_bits[0]`=1 produces a zero sample in the current slot, and the slot count advances.
- R8: In the same idle case with `mode_bits[0]`=0, `out_valid` drops and `out_null` is 1 until a sample is next produced.
- R9: `out_dp` equals `mode_bits[4]` of the held mode.
- R10: While `out_valid`=1 and `out_ready`=0, the output stays unchanged and `in_ready` is 0.
- R11: `mode_bits` and `chan_m1` are taken only at a frame boundary: slot 0 with no buffered half sample. Otherwise the held values apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_bits | input | 5 | Mode word: bit0 silence, bit1 16-bit containers, bit2 MSB at bit 31, bit3 no padding, bit4 DP |
| chan_m1 | input | 3 | Channel count minus one |
| in_data | input | 32 | Raw container word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| out_sample | output | 24 | Audio sample |
| out_chan | output | 3 | Slot index within the frame |
| out_first | output | 1 | First slot of a sample instant |
| out_pad | output | 1 | Padding slot |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Packetizer accepts the sample |
| out_null | output | 1 | Idle with no sample produced (null-packet mode) |
| out_dp | output | 1 | Held DP/HDMI mode select |

## Verification
Two functions can meet in the same cycle: a mode or channel-count change arriving just as a frame closes (on a padding slot or a stalled last slot), and a stall on the packetizer side while a 16-bit word still has its high half buffered. The bench provokes both by rewriting the mode word and channel count on random cycles under random backpressure and random input gaps. A behavioural model that tracks frame position, the buffered half and the held configuration judges every cycle's outputs and `in_ready`.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    localparam int MODE_W      = 5;
    localparam int MB_SILENCE  = 0;
    localparam int MB_HALF     = 1;
    localparam int MB_MSB_HI   = 2;
    localparam int MB_NO_PAD   = 3;
    localparam int MB_DP       = 4;

    typedef struct packed {
        logic dp;
        logic no_pad;
        logic msb_hi;
        logic half;
        logic silence;
    } fmt_mode_t;

    function automatic fmt_mode_t decode_mode(input logic [MODE_W-1:0] b);
        fmt_mode_t m;
        m.dp      = b[MB_DP];
        m.no_pad  = b[MB_NO_PAD];
        m.msb_hi  = b[MB_MSB_HI];
        m.half    = b[MB_HALF];
        m.silence = b[MB_SILENCE];
        return m;
    endfunction

endpackage

// File: rtl/aud_cfg_hold.sv
module aud_cfg_hold
    import aud_fmt_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  fmt_mode_t         mode_live,
    input  logic [CHAN_W-1:0] nch_live,
    output fmt_mode_t         mode_eff,
    output logic [CHAN_W-1:0] nch_eff,
    output fmt_mode_t         mode_held
);

    typedef struct packed {
        fmt_mode_t         mode;
        logic [CHAN_W-1:0] nch;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (at_boundary) begin
            h_d.mode = mode_live;
            h_d.nch  = nch_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign mode_eff  = h_d.mode;
    assign nch_eff   = h_d.nch;
    assign mode_held = h_q.mode;

endmodule

// File: rtl/aud_sample_align.sv
module aud_sample_align #(
    parameter int WORD_W   = 32,
    parameter int SAMPLE_W = 24
) (
    input  logic [WORD_W-1:0]   container,
    input  logic                half_mode,
    input  logic                msb_hi,
    output logic [SAMPLE_W-1:0] sample
);

    localparam int HALF_W = WORD_W / 2;
    localparam int FILL_W = SAMPLE_W - HALF_W;

    always_comb begin
        if (half_mode)
            sample = {container[HALF_W-1:0], {FILL_W{1'b0}}};
        else if (msb_hi)
            sample = container[WORD_W-1:WORD_W-SAMPLE_W];
        else
            sample = container[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/aud_slot_seq.sv
module aud_slot_seq
    import aud_fmt_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int SAMPLE_W = 24,
    parameter int CHAN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_mode_t           mode,
    input  logic [CHAN_W-1:0]   nch_m1,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [WORD_W-1:0]   container,
    input  logic [SAMPLE_W-1:0] aligned,
    output logic                at_boundary,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [CHAN_W-1:0]   out_chan,
    output logic                out_first,
    output logic                out_pad,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_null
);

    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = CHAN_W + 1;

    typedef struct packed {
        logic [CHAN_W-1:0]   slot;
        logic                half_v;
        logic [HALF_W-1:0]   half_data;
        logic                ov;
        logic [SAMPLE_W-1:0] sample;
        logic [CHAN_W-1:0]   chan;
        logic                first;
        logic                pad;
        logic                null_f;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0]    nch;
    logic [CNT_W-1:0]    last_idx;
    logic                pad_on;
    logic                is_pad;
    logic                adv;
    logic                emit;
    logic [SAMPLE_W-1:0] smp;

    assign at_boundary = (s_q.slot == '0) && !s_q.half_v;
    assign container   = s_q.half_v ? {{(WORD_W-HALF_W){1'b0}}, s_q.half_data} : in_data;

    always_comb begin
        s_d      = s_q;
        nch      = CNT_W'(nch_m1) + CNT_W'(1);
        pad_on   = !mode.no_pad && nch[0];
        last_idx = pad_on ? nch : nch - CNT_W'(1);
        is_pad   = pad_on && ({1'b0, s_q.slot} == nch);
        adv      = !s_q.ov || out_ready;
        in_ready = adv && !is_pad && !s_q.half_v;
        emit     = 1'b0;
        smp      = '0;

        if (adv) begin
            if (is_pad) begin
                emit = 1'b1;
            end else if (s_q.half_v) begin
                emit       = 1'b1;
                smp        = aligned;
                s_d.half_v = 1'b0;
            end else if (in_valid) begin
                emit = 1'b1;
                smp  = aligned;
                if (mode.half) begin
                    s_d.half_v    = 1'b1;
                    s_d.half_data = in_data[WORD_W-1:HALF_W];
                end
            end else if (mode.silence) begin
                emit = 1'b1;
            end

            if (emit) begin
                s_d.ov     = 1'b1;
                s_d.sample = smp;
                s_d.chan   = s_q.slot;
                s_d.first  = (s_q.slot == '0);
                s_d.pad    = is_pad;
                s_d.null_f = 1'b0;
                s_d.slot   = ({1'b0, s_q.slot} == last_idx) ? '0 : s_q.slot + CHAN_W'(1);
            end else begin
                s_d.ov     = 1'b0;
                s_d.null_f = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_sample = s_q.sample;
    assign out_chan   = s_q.chan;
    assign out_first  = s_q.first;
    assign out_pad    = s_q.pad;
    assign out_valid  = s_q.ov;
    assign out_null   = s_q.null_f;

endmodule

// File: rtl/aud_slot_formatter.sv
module aud_slot_formatter
    import aud_fmt_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int SAMPLE_W = 24,
    parameter int CHAN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_bits,
    input  logic [CHAN_W-1:0]   chan_m1,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [CHAN_W-1:0]   out_chan,
    output logic                out_first,
    output logic                out_pad,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_null,
    output logic                out_dp
);

    fmt_mode_t           mode_live;
    fmt_mode_t           mode_eff;
    fmt_mode_t           mode_held;
    logic [CHAN_W-1:0]   nch_eff;
    logic                at_boundary;
    logic [WORD_W-1:0]   container;
    logic [SAMPLE_W-1:0] aligned;

    assign mode_live = decode_mode(mode_bits);
    assign out_dp    = mode_held.dp;

    aud_cfg_hold #(.CHAN_W(CHAN_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .at_boundary (at_boundary),
        .mode_live   (mode_live),
        .nch_live    (chan_m1),
        .mode_eff    (mode_eff),
        .nch_eff     (nch_eff),
        .mode_held   (mode_held)
    );

    aud_sample_align #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_align (
        .container (container),
        .half_mode (mode_eff.half),
        .msb_hi    (mode_eff.msb_hi),
        .sample    (aligned)
    );

    aud_slot_seq #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_eff),
        .nch_m1      (nch_eff),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .container   (container),
        .aligned     (aligned),
        .at_boundary (at_boundary),
        .out_sample  (out_sample),
        .out_chan    (out_chan),
        .out_first   (out_first),
        .out_pad     (out_pad),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_null    (out_null)
    );

endmodule

// File: rtl/aud_fmt_checker.sv
module aud_fmt_checker #(
    parameter int SAMPLE_W = 24,
    parameter int CHAN_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_ready,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic [CHAN_W-1:0]   out_chan,
    input logic                out_first,
    input logic                out_pad,
    input logic                out_valid,
    input logic                out_ready,
    input logic                out_null,
    input logic                out_dp,
    input logic                at_boundary
);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_chan)
                                       && $stable(out_first) && $stable(out_pad)));

    assert_stall_noaccept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_first_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_first == (out_chan == '0)));

    assert_pad_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pad) |-> (out_sample == '0 && out_chan != '0));

    assert_null_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_null |-> !out_valid);

    assert_mode_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_dp) |-> $past(at_boundary));

endmodule

bind aud_slot_formatter aud_fmt_checker #(.SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_sample  (out_sample),
    .out_chan    (out_chan),
    .out_first   (out_first),
    .out_pad     (out_pad),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_null    (out_null),
    .out_dp      (out_dp),
    .at_boundary (at_boundary)
);

// File: tb/sim_aud_slot_formatter.sv
`timescale 1ns/1ps
module sim_aud_slot_formatter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_bits = '0;
    logic [2:0]  chan_m1 = '0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] out_sample;
    logic [2:0]  out_chan;
    logic        out_first, out_pad, out_valid, out_null, out_dp;
    logic        out_ready = 1'b1;

    always #10 clk = ~clk;

    aud_slot_formatter u0 (
        .clk(clk), .rst_n(rst_n), .mode_bits(mode_bits), .chan_m1(chan_m1),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_sample(out_sample), .out_chan(out_chan), .out_first(out_first),
        .out_pad(out_pad), .out_valid(out_valid), .out_ready(out_ready),
        .out_null(out_null), .out_dp(out_dp)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_tag = "R1";

    // input word source: written by the stimulus, read pointer owned by the model
    logic [31:0] words [0:4095];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int gap_pct = 0;
    int stall_pct = 0;

    // behavioural reference state
    int          m_slot;
    bit          m_hv;
    logic [15:0] m_hd;
    bit          m_ov;
    logic [23:0] m_os;
    int          m_oc;
    bit          m_of, m_op, m_null;
    logic [4:0]  m_mode;
    logic [2:0]  m_chm1;

    function automatic bit frame_start();
        return (m_slot == 0) && !m_hv;
    endfunction

    function automatic logic [4:0] use_mode();
        return frame_start() ? mode_bits : m_mode;
    endfunction

    function automatic logic [2:0] use_chm1();
        return frame_start() ? chan_m1 : m_chm1;
    endfunction

    function automatic bit needs_pad(logic [4:0] md, logic [2:0] cm);
        int n = int'(cm) + 1;
        return !md[3] && (n % 2 == 1);
    endfunction

    function automatic bit pad_now();
        logic [4:0] md = use_mode();
        logic [2:0] cm = use_chm1();
        return needs_pad(md, cm) && (m_slot == int'(cm) + 1);
    endfunction

    function automatic bit exp_ready();
        return (!m_ov || out_ready) && !pad_now() && !m_hv;
    endfunction

    always @(posedge clk) begin : model
        logic [4:0]  md;
        logic [2:0]  cm;
        logic [23:0] smp;
        bit          pd, got;
        int          total;
        if (!rst_n) begin
            m_slot = 0; m_hv = 0; m_hd = '0; m_ov = 0; m_os = '0; m_oc = 0;
            m_of = 0; m_op = 0; m_null = 0; m_mode = '0; m_chm1 = '0;
        end else begin
            md = use_mode();
            cm = use_chm1();
            pd = pad_now();
            total = int'(cm) + 1 + (needs_pad(md, cm) ? 1 : 0);
            m_mode = md;
            m_chm1 = cm;
            if (!m_ov || out_ready) begin
                got = 1;
                smp = '0;
                if (pd) begin
                    smp = '0;
                end else if (m_hv) begin
                    smp = {m_hd, 8'h00};
                    m_hv = 0;
                end else if (in_valid) begin
                    rd_cnt++;
                    if (md[1]) begin
                        smp = {in_data[15:0], 8'h00};
                        m_hv = 1;
                        m_hd = in_data[31:16];
                    end else if (md[2]) begin
                        smp = in_data[31:8];
                    end else begin
                        smp = in_data[23:0];
                    end
                end else if (!md[0]) begin
                    got = 0;
                end
                if (got) begin
                    m_ov = 1; m_os = smp; m_oc = m_slot; m_of = (m_slot == 0);
                    m_op = pd; m_null = 0;
                    m_slot = (m_slot + 1) % total;
                end else begin
                    m_ov = 0; m_null = 1;
                end
            end
        end
    end

    task automatic fail_line(string tag, string what, int act, int exp);
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic compare();
        bit bad = 0;
        checks++;
        if (in_ready !== exp_ready()) begin bad = 1; fail_line(cur_tag, "in_ready", int'(in_ready), int'(exp_ready())); end
        if (out_valid !== m_ov) begin bad = 1; fail_line(cur_tag, "out_valid", int'(out_valid), int'(m_ov)); end
        if (out_null !== m_null) begin bad = 1; fail_line("R8", "out_null", int'(out_null), int'(m_null)); end
        if (out_dp !== m_mode[4]) begin bad = 1; fail_line("R9", "out_dp", int'(out_dp), int'(m_mode[4])); end
        if (m_ov) begin
            if (out_sample !== m_os) begin bad = 1; fail_line(cur_tag, "out_sample", int'(out_sample), int'(m_os)); end
            if (int'(out_chan) != m_oc) begin bad = 1; fail_line("R5", "out_chan", int'(out_chan), m_oc); end
            if (out_first !== m_of) begin bad = 1; fail_line("R5", "out_first", int'(out_first), int'(m_of)); end
            if (out_pad !== m_op) begin bad = 1; fail_line("R6", "out_pad", int'(out_pad), int'(m_op)); end
        end
        if (bad) errors++;
    endtask

    task automatic check1(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin errors++; fail_line(tag, what, act, exp); end
    endtask

    task automatic step();
        @(negedge clk);
        out_ready = ($urandom_range(0, 99) >= stall_pct);
        if (rd_cnt < wr_cnt && $urandom_range(0, 99) >= gap_pct) begin
            in_valid = 1'b1;
            in_data  = words[rd_cnt];
        end else begin
            in_valid = 1'b0;
            in_data  = $urandom;
        end
        #1;
        if (rst_n) compare();
    endtask

    task automatic push_words(int n);
        for (int i = 0; i < n; i++) begin
            words[wr_cnt % 4096] = $urandom;
            wr_cnt++;
        end
    endtask

    task automatic run_phase(string tag, logic [4:0] md, logic [2:0] cm, int n, int gp, int sp);
        cur_tag   = tag;
        mode_bits = md;
        chan_m1   = cm;
        gap_pct   = gp;
        stall_pct = sp;
        push_words(n);
        for (int k = 0; k < 4000 && rd_cnt < wr_cnt; k++) step();
        stall_pct = 0;
        for (int k = 0; k < 20; k++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) step();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state right after reset
        check1(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check1(out_null == 1'b0, "R1", "out_null", int'(out_null), 0);
        check1(out_dp == 1'b0, "R1", "out_dp", int'(out_dp), 0);
        check1(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

        run_phase("R2", 5'b00000, 3'd1, 24, 0, 0);
        run_phase("R3", 5'b00100, 3'd5, 30, 10, 0);
        run_phase("R4", 5'b00010, 3'd3, 30, 20, 20);
        run_phase("R5", 5'b00000, 3'd7, 32, 0, 10);
        run_phase("R6", 5'b00000, 3'd4, 30, 10, 10);
        run_phase("R6", 5'b01000, 3'd2, 30, 10, 10);
        run_phase("R6", 5'b00010, 3'd2, 30, 0, 0);
        run_phase("R7", 5'b00001, 3'd3, 30, 60, 0);

        run_phase("R8", 5'b00000, 3'd1, 20, 50, 0);
        // R8: source dry and silence off leaves the output idle in null mode
        check1(out_null == 1'b1, "R8", "out_null idle", int'(out_null), 1);
        check1(out_valid == 1'b0, "R8", "out_valid idle", int'(out_valid), 0);

        run_phase("R9", 5'b10000, 3'd1, 16, 0, 0);
        // R9: held DP select reaches the mode output
        check1(out_dp == 1'b1, "R9", "out_dp", int'(out_dp), 1);

        run_phase("R10", 5'b00000, 3'd2, 40, 10, 60);
        run_phase("R10", 5'b00010, 3'd4, 40, 10, 60);

        // R11: configuration rewritten at random cycles under random backpressure
        cur_tag   = "R11";
        gap_pct   = 25;
        stall_pct = 30;
        for (int k = 0; k < 3000; k++) begin
            if (wr_cnt - rd_cnt < 8) push_words(16);
            if ($urandom_range(0, 99) < 15) begin
                mode_bits = 5'($urandom);
                chan_m1   = 3'($urandom);
            end
            step();
        end
        stall_pct = 0;
        mode_bits = 5'b00001;
        for (int k = 0; k < 60; k++) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule